// File: doc/BRIEF.md
# Bridge Transaction Ordering Scheduler

This block decides the issue order for one direction of a two-port bus-to-bus bridge. Three kinds of work arrive on three separate valid/ready inputs: posted writes, delayed requests (read or write) and delayed completions (read or write). Completions come in on their own port because they travel opposite to the requests that caused them. Each kind is held in its own first-in first-out queue. Every cycle the block offers one queue head on a single valid/ready output, tagged with a kind code. It drops that entry once the downstream side accepts it.

Which head may go is set by a fixed pass-permission matrix:
- A posted write may overtake any non-posted entry.
- Requests and read completions may not overtake an older posted write.
- A write completion may overtake a posted write.
- Completions may overtake requests.
- No kind overtakes its own kind.

Each request and completion entry records how many posted writes were ahead of it when it arrived. That count drops as those writes leave, and a barred entry becomes eligible when it reaches zero. Among the eligible heads, posted writes win, then completions, then requests. The other direction of the bridge is a separate, independent instance.

Top module: `bridge_order_sched`

## Requirements
- R1: Posted writes leave on the output in the order they were accepted, and never ahead of an older posted write.
- R2: `pw_ready` is high whenever the posted queue holds fewer than PW_DEPTH entries, whatever the other queues or `out_ready` are doing, and low only when it is full.
- R3: `rq_ready` is low exactly when the request queue holds RQ_DEPTH entries, and `cp_ready` is low exactly when the completion queue holds CP_DEPTH entries.
- R4: Requests (read and write together) leave in acceptance order, and never ahead of an older pending posted write.
- R5: Completions (read and write together) leave in acceptance order. A read completion never leaves ahead of an older pending posted write. A completion may leave ahead of older requests.
- R6: The offered entry is the posted head whenever the posted queue is non-empty. Otherwise it is the completion head, and otherwise the request head.
- R7: `out_kind` is 0 for a posted write, 1 for a read request, 2 for a write request, 3 for a read completion and 4 for a write completion. The read/write choice comes from `rq_write`/`cp_write` (1 = write). `out_tag` is the tag given with that entry on input.
- R8: `out_valid` is high exactly when some queue is non-empty. An entry is removed only in a cycle with `out_valid` and `out_ready` both high. With `out_ready` low and no input accepted, `out_kind` and `out_tag` hold.
- R9: After reset all queues are empty, `out_valid` is low and all three input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Posted write offered |
| pw_ready | output | 1 | Posted queue can accept |
| pw_tag | input | TAG_W | Posted write tag |
| rq_valid | input | 1 | Delayed request offered |
| rq_ready | output | 1 | Request queue can accept |
| rq_write | input | 1 | 1 = write request, 0 = read request |
| rq_tag | input | TAG_W | Request tag |
| cp_valid | input | 1 | Delayed completion offered |
| cp_ready | output | 1 | Completion queue can accept |
| cp_write | input | 1 | 1 = write completion, 0 = read completion |
| cp_tag | input | TAG_W | Completion tag |
| out_valid | output | 1 | An entry is offered downstream |
| out_ready | input | 1 | Downstream accepts the offered entry |
| out_kind | output | 3 | Kind code of the offered entry |
| out_tag | output | TAG_W | Tag of the offered entry |

## Verification
The assertions assume that every input is a known value once reset is released. They place no hold rule on input offers: a source may change or withdraw its tag, write flag or valid after seeing ready low. The assertions also assume that downstream may stall for any number of cycles. The bench stays inside these assumptions. It drives a fresh, known tag and write flag on every port every cycle, and it toggles each valid and `out_ready` independently. It uses several rate mixes, from a nearly idle output to a saturated one, so that all three queues fill, drain and refill many times.

// File: rtl/bridge_order_sched.sv
module bridge_order_sched #(
  parameter int PW_DEPTH = 4,
  parameter int RQ_DEPTH = 4,
  parameter int CP_DEPTH = 4,
  parameter int TAG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pw_valid,
  output logic             pw_ready,
  input  logic [TAG_W-1:0] pw_tag,
  input  logic             rq_valid,
  output logic             rq_ready,
  input  logic             rq_write,
  input  logic [TAG_W-1:0] rq_tag,
  input  logic             cp_valid,
  output logic             cp_ready,
  input  logic             cp_write,
  input  logic [TAG_W-1:0] cp_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_kind,
  output logic [TAG_W-1:0] out_tag
);
  localparam int PA = (PW_DEPTH > 1) ? $clog2(PW_DEPTH) : 1;
  localparam int RA = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1;
  localparam int CA = (CP_DEPTH > 1) ? $clog2(CP_DEPTH) : 1;
  localparam int PC = $clog2(PW_DEPTH + 1);
  localparam int RC = $clog2(RQ_DEPTH + 1);
  localparam int CC = $clog2(CP_DEPTH + 1);
  localparam logic [1:0] S_PW = 2'd0, S_CP = 2'd1, S_RQ = 2'd2, S_NONE = 2'd3;

  logic [TAG_W-1:0]    pw_mem [PW_DEPTH];
  logic [PA-1:0]       pw_rp, pw_wp;
  logic [PC-1:0]       pw_cnt;

  logic [TAG_W-1:0]    rq_mem [RQ_DEPTH];
  logic [RQ_DEPTH-1:0] rq_wr_q;
  logic [PC-1:0]       rq_bar [RQ_DEPTH];
  logic [RA-1:0]       rq_rp, rq_wp;
  logic [RC-1:0]       rq_cnt;

  logic [TAG_W-1:0]    cp_mem [CP_DEPTH];
  logic [CP_DEPTH-1:0] cp_wr_q;
  logic [PC-1:0]       cp_bar [CP_DEPTH];
  logic [CA-1:0]       cp_rp, cp_wp;
  logic [CC-1:0]       cp_cnt;

  logic pw_push, rq_push, cp_push, pw_pop, rq_pop, cp_pop, fire;
  logic rq_el, cp_el;
  logic [1:0] sel;
  logic [PC-1:0] bar_in;

  assign pw_ready = pw_cnt != PC'(PW_DEPTH);
  assign rq_ready = rq_cnt != RC'(RQ_DEPTH);
  assign cp_ready = cp_cnt != CC'(CP_DEPTH);
  assign pw_push  = pw_valid & pw_ready;
  assign rq_push  = rq_valid & rq_ready;
  assign cp_push  = cp_valid & cp_ready;

  // posted writes still ahead of an entry arriving this cycle
  assign bar_in = pw_cnt + PC'(pw_push) - PC'(pw_pop);

  assign rq_el = (rq_cnt != '0) && (rq_bar[rq_rp] == '0);
  assign cp_el = (cp_cnt != '0) && (cp_wr_q[cp_rp] || (cp_bar[cp_rp] == '0));

  always_comb begin
    if (pw_cnt != '0)  sel = S_PW;
    else if (cp_el)    sel = S_CP;
    else if (rq_el)    sel = S_RQ;
    else               sel = S_NONE;
  end

  assign out_valid = sel != S_NONE;
  assign fire      = out_valid & out_ready;
  assign pw_pop    = fire && (sel == S_PW);
  assign cp_pop    = fire && (sel == S_CP);
  assign rq_pop    = fire && (sel == S_RQ);

  always_comb begin
    out_kind = 3'd0;
    out_tag  = '0;
    case (sel)
      S_PW: begin
        out_kind = 3'd0;
        out_tag  = pw_mem[pw_rp];
      end
      S_RQ: begin
        out_kind = rq_wr_q[rq_rp] ? 3'd2 : 3'd1;
        out_tag  = rq_mem[rq_rp];
      end
      S_CP: begin
        out_kind = cp_wr_q[cp_rp] ? 3'd4 : 3'd3;
        out_tag  = cp_mem[cp_rp];
      end
      default: ;
    endcase
  end

  // posted queue
  always_ff @(posedge clk) begin
    if (pw_push) pw_mem[pw_wp] <= pw_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_rp  <= '0;
      pw_wp  <= '0;
      pw_cnt <= '0;
    end else begin
      if (pw_push) pw_wp <= (pw_wp == PA'(PW_DEPTH - 1)) ? '0 : pw_wp + PA'(1);
      if (pw_pop)  pw_rp <= (pw_rp == PA'(PW_DEPTH - 1)) ? '0 : pw_rp + PA'(1);
      pw_cnt <= pw_cnt + PC'(pw_push) - PC'(pw_pop);
    end
  end

  // request queue
  always_ff @(posedge clk) begin
    if (rq_push) begin
      rq_mem[rq_wp]  <= rq_tag;
      rq_wr_q[rq_wp] <= rq_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_rp  <= '0;
      rq_wp  <= '0;
      rq_cnt <= '0;
      for (int i = 0; i < RQ_DEPTH; i++) rq_bar[i] <= '0;
    end else begin
      if (rq_push) rq_wp <= (rq_wp == RA'(RQ_DEPTH - 1)) ? '0 : rq_wp + RA'(1);
      if (rq_pop)  rq_rp <= (rq_rp == RA'(RQ_DEPTH - 1)) ? '0 : rq_rp + RA'(1);
      rq_cnt <= rq_cnt + RC'(rq_push) - RC'(rq_pop);
      for (int i = 0; i < RQ_DEPTH; i++) begin
        if (rq_push && (rq_wp == RA'(i)))       rq_bar[i] <= bar_in;
        else if (pw_pop && (rq_bar[i] != '0))   rq_bar[i] <= rq_bar[i] - PC'(1);
      end
    end
  end

  // completion queue
  always_ff @(posedge clk) begin
    if (cp_push) begin
      cp_mem[cp_wp]  <= cp_tag;
      cp_wr_q[cp_wp] <= cp_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_rp  <= '0;
      cp_wp  <= '0;
      cp_cnt <= '0;
      for (int i = 0; i < CP_DEPTH; i++) cp_bar[i] <= '0;
    end else begin
      if (cp_push) cp_wp <= (cp_wp == CA'(CP_DEPTH - 1)) ? '0 : cp_wp + CA'(1);
      if (cp_pop)  cp_rp <= (cp_rp == CA'(CP_DEPTH - 1)) ? '0 : cp_rp + CA'(1);
      cp_cnt <= cp_cnt + CC'(cp_push) - CC'(cp_pop);
      for (int i = 0; i < CP_DEPTH; i++) begin
        if (cp_push && (cp_wp == CA'(i)))       cp_bar[i] <= bar_in;
        else if (pw_pop && (cp_bar[i] != '0))   cp_bar[i] <= cp_bar[i] - PC'(1);
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pw_cnt <= PC'(PW_DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cnt <= RC'(RQ_DEPTH)) && (cp_cnt <= CC'(CP_DEPTH)));

  assert_barrier_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cnt != '0) |-> (rq_bar[rq_rp] <= pw_cnt));

  assert_rd_cpl_no_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == 3'd3)) |-> (pw_cnt == '0));

  assert_req_after_posted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((out_kind == 3'd1) || (out_kind == 3'd2))) |-> (pw_cnt == '0));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pw_cnt != '0) || (rq_cnt != '0) || (cp_cnt != '0)) |-> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pw_push && !rq_push && !cp_push)
      |=> (out_valid && $stable(out_kind) && $stable(out_tag)));
endmodule

// File: tb/bridge_order_sched_tb.sv
module bridge_order_sched_tb;
  localparam int D  = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pw_valid = 1'b0, rq_valid = 1'b0, cp_valid = 1'b0;
  logic rq_write = 1'b0, cp_write = 1'b0, out_ready = 1'b0;
  logic [TW-1:0] pw_tag = '0, rq_tag = '0, cp_tag = '0;
  logic pw_ready, rq_ready, cp_ready, out_valid;
  logic [2:0] out_kind;
  logic [TW-1:0] out_tag;

  always #10 clk = ~clk;

  bridge_order_sched #(.PW_DEPTH(D), .RQ_DEPTH(D), .CP_DEPTH(D), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_tag(pw_tag),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write), .rq_tag(rq_tag),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_write(cp_write), .cp_tag(cp_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_tag(out_tag)
  );

  int n_chk = 0, n_bad = 0;
  int pwq[$], rqq[$], cpq[$];
  int arr_ctr = 0, tag_ctr = 0;

  // model entry: arrival*4096 + kind*256 + tag
  function automatic int e_arr(int e);  return e / 4096;        endfunction
  function automatic int e_kind(int e); return (e / 256) % 16;  endfunction
  function automatic int e_tag(int e);  return e % 256;         endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit may_pass(int kn, int ko);
    case (kn)
      0:       return ko != 0;
      1, 2:    return ko >= 3;
      3:       return (ko == 1) || (ko == 2);
      default: return ko <= 2;
    endcase
  endfunction

  task automatic step(input bit pv, input bit rv, input bit rw, input bit cv, input bit cw,
                      input bit ordy);
    bit ev, pf, rf, cf, of, bad;
    int got;
    string rn;
    @(negedge clk);
    pw_valid = pv; pw_tag = TW'(tag_ctr);
    rq_valid = rv; rq_write = rw; rq_tag = TW'(tag_ctr + 1);
    cp_valid = cv; cp_write = cw; cp_tag = TW'(tag_ctr + 2);
    out_ready = ordy;
    #2;
    ev = (pwq.size() + rqq.size() + cpq.size()) != 0;
    got = 0;
    if (pwq.size() != 0)      got = pwq[0];
    else if (cpq.size() != 0) got = cpq[0];
    else if (rqq.size() != 0) got = rqq[0];
    chk(out_valid == ev, "R8 out_valid", int'(out_valid), int'(ev));
    if (ev && out_valid) begin
      chk(int'(out_kind) == e_kind(got), "R6 selected kind", int'(out_kind), e_kind(got));
      chk(int'(out_tag) == e_tag(got), "R7 offered tag", int'(out_tag), e_tag(got));
    end
    chk(pw_ready == (pwq.size() < D), "R2 pw_ready", int'(pw_ready), int'(pwq.size() < D));
    chk(rq_ready == (rqq.size() < D), "R3 rq_ready", int'(rq_ready), int'(rqq.size() < D));
    chk(cp_ready == (cpq.size() < D), "R3 cp_ready", int'(cp_ready), int'(cpq.size() < D));
    pf = pv && pw_ready;
    rf = rv && rq_ready;
    cf = cv && cp_ready;
    of = out_valid && out_ready;
    if (of && ev) begin
      bad = 1'b0;
      foreach (pwq[i]) if (e_arr(pwq[i]) < e_arr(got) && !may_pass(e_kind(got), e_kind(pwq[i]))) bad = 1'b1;
      foreach (rqq[i]) if (e_arr(rqq[i]) < e_arr(got) && !may_pass(e_kind(got), e_kind(rqq[i]))) bad = 1'b1;
      foreach (cpq[i]) if (e_arr(cpq[i]) < e_arr(got) && !may_pass(e_kind(got), e_kind(cpq[i]))) bad = 1'b1;
      rn = (e_kind(got) == 0) ? "R1 pass rule" : (e_kind(got) <= 2) ? "R4 pass rule" : "R5 pass rule";
      chk(!bad, rn, int'(bad), 0);
      if (e_kind(got) == 0)      void'(pwq.pop_front());
      else if (e_kind(got) >= 3) void'(cpq.pop_front());
      else                       void'(rqq.pop_front());
    end
    @(posedge clk);
    if (pf) begin pwq.push_back(arr_ctr * 4096 + e_tag(tag_ctr)); arr_ctr++; end
    if (rf) begin rqq.push_back(arr_ctr * 4096 + (rw ? 2 : 1) * 256 + e_tag(tag_ctr + 1)); arr_ctr++; end
    if (cf) begin cpq.push_back(arr_ctr * 4096 + (cw ? 4 : 3) * 256 + e_tag(tag_ctr + 2)); arr_ctr++; end
    tag_ctr += 3;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(pw_ready == 1'b1, "R9 pw_ready after reset", int'(pw_ready), 1);
    chk(rq_ready && cp_ready, "R9 rq/cp ready after reset", int'(rq_ready && cp_ready), 1);

    // fill everything with the output stalled, then drain
    for (int c = 0; c < 6; c++) step(1, 1, c[0], 1, c[1], 0);
    for (int c = 0; c < 14; c++) step(0, 0, 0, 0, 0, 1);
    // non-posted only, then posted arriving behind them
    for (int c = 0; c < 3; c++) step(0, 1, c[0], 1, !c[0], 0);
    for (int c = 0; c < 3; c++) step(1, 0, 0, 0, 0, 0);
    for (int c = 0; c < 14; c++) step(0, 0, 0, 0, 0, 1);

    for (int p = 0; p < 6; p++) begin
      int tp, tr, tc, to;
      case (p)
        0:       begin tp = 50; tr = 50; tc = 50; to = 50;  end
        1:       begin tp = 90; tr = 30; tc = 30; to = 20;  end
        2:       begin tp = 10; tr = 60; tc = 60; to = 90;  end
        3:       begin tp = 80; tr = 80; tc = 80; to = 100; end
        4:       begin tp = 30; tr = 30; tc = 30; to = 5;   end
        default: begin tp = 0;  tr = 70; tc = 70; to = 40;  end
      endcase
      for (int c = 0; c < 3000; c++)
        step($urandom_range(0, 99) < tp, $urandom_range(0, 99) < tr, $urandom_range(0, 1) == 1,
             $urandom_range(0, 99) < tc, $urandom_range(0, 1) == 1, $urandom_range(0, 99) < to);
      for (int c = 0; c < 14; c++) step(0, 0, 0, 0, 0, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R8 actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule